// File: doc/BRIEF.md
# 32-bit Single-Error-Correcting, Double-Error-Detecting Memory Guard

This block protects a 32-bit memory word with a 7-bit check word. When data goes to memory, the block computes the check word from the data bus. When the word and its check bits come back, the block computes the check bits again from the returned data. It compares the two sets and grades the result on two active-low flags: clean, correctable, or uncorrectable. In correct mode it drives the repaired data word and puts the syndrome on the check port.

The check bits do not all use the same parity polarity. The three lowest are odd parity (XNOR of their selected data bits) and the four highest are even parity (XOR). The syndrome is the bitwise XNOR of the stored and regenerated check words, so a clean word gives all ones. The data and check inputs pass through a capture stage. The stage follows the live inputs while the capture enable is high and holds the last captured word while it is low.

Top module: `edac_sec_ded`

## Requirements
- R1: With `mode_sel` = 00, `chk_out` carries the generated check word. Bit 0 is the XNOR of data bits {0,4,6,7,8,9,11,14,17,18,19,21,26,28,29,31}. Bits 0 to 2 are XNOR parities and bits 3 to 6 are XOR parities, so all-zero data gives 0x07 and data 0x00000001 gives 0x48.
- R2: With `mode_sel` = 10 and a word plus check bits as written, both flags are high, `data_out` shows the input data and `chk_out` echoes the stored check input.
- R3: A flip of any one of the 39 stored bits (32 data, 7 check) drives `err_n` low and `merr_n` high in modes 10 and 11.
- R4: Any two flipped bits (data/data, check/check or data/check) drive both `err_n` and `merr_n` low. `merr_n` is never low while `err_n` is high.
- R5: With `mode_sel` = 11, `data_out` equals the originally written data when there is no error or one flipped bit, including a flip in a check bit.
- R6: With `mode_sel` = 11, `chk_out` is the syndrome. It is 0x7F for a clean word. For a single flip in check bit k it is all ones except bit k.
- R7: For a single flip in data bit j, the syndrome holds an odd count of zeros, at least three. These 32 syndromes are all distinct.
- R8: While `lat_en` is high, the outputs follow the live inputs. While `lat_en` is low, they use the word captured at the last rising clock edge with `lat_en` high.
- R9: In modes 00 and 01 (both write), both flags stay high and `chk_out` is the generated check word.
- R10: Synchronous reset clears the captured word to zero. After reset, with `lat_en` low and `mode_sel` = 00, `data_out` is 0 and `chk_out` is 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture stage |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00/01 write, 10 read and flag, 11 correct |
| lat_en | input | 1 | High: follow the live inputs; low: hold the captured word |
| data_in | input | 32 | Data word from the bus or memory |
| chk_in | input | 7 | Stored check word from memory |
| data_out | output | 32 | Data word, corrected in mode 11 |
| chk_out | output | 7 | Generated check word, echoed check word or syndrome, depending on mode |
| err_n | output | 1 | Low on any detected error |
| merr_n | output | 1 | Low on an uncorrectable error |

## Verification
The bench flips each of the 39 stored bits in turn. A decoder that confused a check-bit flip with a data-bit flip would corrupt `data_out` or report a wrong syndrome. The bench also confirms the 32 data-bit syndromes are distinct with odd zero counts; a duplicate column would repair the wrong bit. Double flips of all three kinds must pull both flags low, where a parity-only classifier would call them correctable. The bench pins the mixed parity polarity through the 0x07 and 0x48 words and the CB0 set. It then drops `lat_en` and drives changing live data, which a design that ignored the hold would pass straight through.

// File: rtl/edac_pkg.sv
package edac_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int ODD_CB = 3;   // check bits below this index use XNOR parity
    localparam int CODE_N = 1 << CHK_W;

    // data bits that feed check bit 0
    localparam logic [DATA_W-1:0] CB0_MEMBERS = 32'hB42E_4BD1;
    // column of data bit 0: check bits 0,1,2,3,6
    localparam logic [CHK_W-1:0]  BIT0_CODE   = 7'h4F;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [DATA_W-1:0][CHK_W-1:0] col_arr_t;
    typedef logic [CHK_W-1:0][DATA_W-1:0] row_arr_t;

    typedef enum logic [1:0] {
        MODE_WRITE     = 2'b00,
        MODE_WRITE_ALT = 2'b01,
        MODE_FLAG      = 2'b10,
        MODE_CORRECT   = 2'b11
    } edac_mode_e;

    typedef struct packed {
        data_t data;
        chk_t  chk;
    } word_t;

    typedef struct packed {
        logic err_n;
        logic merr_n;
    } flags_t;

    function automatic int popcount_chk(input chk_t v);
        int n;
        n = 0;
        for (int i = 0; i < CHK_W; i++) n += int'(v[i]);
        return n;
    endfunction

    // Each data bit gets a distinct odd-weight code of weight >= 3 whose
    // bit 0 agrees with the fixed check-bit-0 membership.
    function automatic col_arr_t build_cols();
        col_arr_t cols;
        int   p_in;
        int   p_out;
        int   lo;
        logic hit;
        logic want;
        chk_t code;
        cols  = '0;
        p_in  = 1;
        p_out = 1;
        for (int j = 0; j < DATA_W; j++) begin
            if (j == 0) begin
                cols[j] = BIT0_CODE;
            end else begin
                hit  = 1'b0;
                want = CB0_MEMBERS[j];
                lo   = want ? p_in : p_out;
                for (int c = 1; c < CODE_N; c++) begin
                    code = chk_t'(c);
                    if (!hit && c >= lo && code[0] == want && code != BIT0_CODE
                        && popcount_chk(code) >= 3 && popcount_chk(code) % 2 == 1) begin
                        cols[j] = code;
                        hit     = 1'b1;
                        if (want) p_in = c + 1;
                        else      p_out = c + 1;
                    end
                end
            end
        end
        return cols;
    endfunction

    localparam col_arr_t COLS = build_cols();

    function automatic row_arr_t build_rows();
        row_arr_t rows;
        for (int r = 0; r < CHK_W; r++)
            for (int j = 0; j < DATA_W; j++)
                rows[r][j] = COLS[j][r];
        return rows;
    endfunction

    localparam row_arr_t ROW_MASKS = build_rows();

endpackage

// File: rtl/edac_in_latch.sv
module edac_in_latch
    import edac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lat_en,
    input  word_t live,
    output word_t eff
);
    word_t held;

    always_ff @(posedge clk) begin
        if (rst)         held <= '0;
        else if (lat_en) held <= live;
    end

    assign eff = lat_en ? live : held;

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !lat_en |=> $stable(held));

endmodule

// File: rtl/edac_checkgen.sv
module edac_checkgen
    import edac_pkg::*;
(
    input  data_t data,
    output chk_t  chk
);
    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        if (r < ODD_CB) begin : g_odd
            assign chk[r] = ~^(data & ROW_MASKS[r]);
        end else begin : g_even
            assign chk[r] = ^(data & ROW_MASKS[r]);
        end
    end

endmodule

// File: rtl/edac_decode.sv
module edac_decode
    import edac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  word_t  word,
    input  chk_t   regen,
    output chk_t   syn,
    output data_t  fixed,
    output flags_t flags
);
    chk_t  zeros;
    data_t flip;
    logic  any_err;
    logic  chk_hit;
    logic  fixable;

    assign syn   = ~(word.chk ^ regen);
    assign zeros = ~syn;

    for (genvar j = 0; j < DATA_W; j++) begin : g_col
        assign flip[j] = (zeros == COLS[j]);
    end

    assign fixed = word.data ^ flip;

    always_comb begin
        any_err      = |zeros;
        chk_hit      = (popcount_chk(zeros) == 1);
        fixable      = (^zeros) && ((|flip) || chk_hit);
        flags.err_n  = ~any_err;
        flags.merr_n = ~(any_err && !fixable);
    end

    assert_flag_grade_R4: assert property (@(posedge clk) disable iff (rst)
        !flags.merr_n |-> !flags.err_n);

endmodule

// File: rtl/edac_sec_ded.sv
module edac_sec_ded
    import edac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_sel,
    input  logic        lat_en,
    input  logic [31:0] data_in,
    input  logic [6:0]  chk_in,
    output logic [31:0] data_out,
    output logic [6:0]  chk_out,
    output logic        err_n,
    output logic        merr_n
);
    edac_mode_e mode;
    word_t      live;
    word_t      eff;
    chk_t       regen;
    chk_t       syn;
    data_t      fixed;
    flags_t     flags;

    assign mode = edac_mode_e'(mode_sel);
    assign live = '{data: data_in, chk: chk_in};

    edac_in_latch i_latch (
        .clk    (clk),
        .rst    (rst),
        .lat_en (lat_en),
        .live   (live),
        .eff    (eff)
    );

    edac_checkgen i_gen (
        .data (eff.data),
        .chk  (regen)
    );

    edac_decode i_dec (
        .clk   (clk),
        .rst   (rst),
        .word  (eff),
        .regen (regen),
        .syn   (syn),
        .fixed (fixed),
        .flags (flags)
    );

    always_comb begin
        data_out = eff.data;
        chk_out  = regen;
        err_n    = 1'b1;
        merr_n   = 1'b1;
        case (mode)
            MODE_FLAG: begin
                chk_out = eff.chk;
                err_n   = flags.err_n;
                merr_n  = flags.merr_n;
            end
            MODE_CORRECT: begin
                data_out = fixed;
                chk_out  = syn;
                err_n    = flags.err_n;
                merr_n   = flags.merr_n;
            end
            default: ;
        endcase
    end

    assert_write_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !mode_sel[1] |-> (err_n && merr_n));

    assert_single_fix_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11) |-> $onehot0(data_out ^ eff.data));

    assert_clean_syndrome_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11) |-> (err_n == (chk_out == 7'h7F)));

    assert_clean_nofix_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11 && err_n) |-> (data_out == eff.data));

endmodule

// File: tb/test_edac_sec_ded.sv
module test_edac_sec_ded;

    typedef struct {
        logic [31:0] d_exp;
        logic        d_chk;
        logic [6:0]  c_exp;
        logic [6:0]  c_mask;
        logic        e_exp;
        logic        m_exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic        lat_en = 1'b0;
    logic [31:0] data_in = '0;
    logic [6:0]  chk_in = '0;
    logic [31:0] data_out;
    logic [6:0]  chk_out;
    logic        err_n;
    logic        merr_n;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;
    exp_t q[$];

    localparam logic [31:0] CB0_SET = 32'hB42E_4BD1;

    always #5 clk = ~clk;

    edac_sec_ded i_edac_sec_ded (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .lat_en(lat_en),
        .data_in(data_in), .chk_in(chk_in), .data_out(data_out),
        .chk_out(chk_out), .err_n(err_n), .merr_n(merr_n)
    );

    function automatic exp_t mk(input logic [31:0] d, input logic dc,
                                input logic [6:0] c, input logic [6:0] cm,
                                input logic e, input logic m, input string t);
        exp_t x;
        x.d_exp = d; x.d_chk = dc; x.c_exp = c; x.c_mask = cm;
        x.e_exp = e; x.m_exp = m; x.tag = t;
        return x;
    endfunction

    task automatic drive(input logic [1:0] m, input logic le, input logic [31:0] d,
                         input logic [6:0] c, input exp_t e);
        @(posedge clk); #2;
        mode_sel = m; lat_en = le; data_in = d; chk_in = c;
        q.push_back(e);
    endtask

    // monitor: compares one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ((e.d_chk && data_out !== e.d_exp) ||
                ((chk_out & e.c_mask) !== (e.c_exp & e.c_mask)) ||
                err_n !== e.e_exp || merr_n !== e.m_exp) begin
                errors++;
                $display("FAIL %s: data=%h chk=%h err_n=%b merr_n=%b expected data=%h chk=%h/%h err_n=%b merr_n=%b",
                         e.tag, data_out, chk_out, err_n, merr_n,
                         e.d_exp, e.c_exp, e.c_mask, e.e_exp, e.m_exp);
            end
        end
    end

    task automatic encode(input logic [31:0] d, output logic [6:0] cw);
        @(posedge clk); #2;
        mode_sel = 2'b00; lat_en = 1'b1; data_in = d; chk_in = '0;
        @(negedge clk); #1;
        cw = chk_out;
    endtask

    function automatic logic [38:0] flip1(input logic [31:0] d, input logic [6:0] c, input int b);
        return {c, d} ^ (39'd1 << b);
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] words [5];
        logic [6:0]  cw;
        logic [6:0]  syns [32];
        words[0] = 32'h0000_0000; words[1] = 32'hFFFF_FFFF; words[2] = 32'hA5A5_5A5A;
        words[3] = 32'h1234_5678; words[4] = 32'h8000_0001;

        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R10: reset cleared the held word; lat_en low
        drive(2'b00, 1'b0, 32'hDEAD_BEEF, 7'h55, mk(32'h0, 1, 7'h07, 7'h7F, 1, 1, "R10 reset state"));

        // R1: fixed check words and CB0 membership
        drive(2'b00, 1'b1, 32'h0, 7'h0, mk(32'h0, 1, 7'h07, 7'h7F, 1, 1, "R1 zero word"));
        drive(2'b00, 1'b1, 32'h1, 7'h0, mk(32'h1, 1, 7'h48, 7'h7F, 1, 1, "R1 word 0x1"));
        for (int i = 0; i < 5; i++)
            drive(2'b00, 1'b1, words[i] ^ 32'h0F0F_3C3C, 7'h0,
                  mk(words[i] ^ 32'h0F0F_3C3C, 1, {6'd0, ~^((words[i] ^ 32'h0F0F_3C3C) & CB0_SET)},
                     7'h01, 1, 1, "R1 CB0 parity"));

        for (int w = 0; w < 5; w++) begin
            encode(words[w], cw);
            // R9: alternate write encoding matches, flags idle
            drive(2'b01, 1'b1, words[w], 7'h0, mk(words[w], 1, cw, 7'h7F, 1, 1, "R9 mode 01"));
            // R2: clean read-and-flag
            drive(2'b10, 1'b1, words[w], cw, mk(words[w], 1, cw, 7'h7F, 1, 1, "R2 clean flag"));
            // R6/R5: clean correct
            drive(2'b11, 1'b1, words[w], cw, mk(words[w], 1, 7'h7F, 7'h7F, 1, 1, "R6 clean syndrome"));
            for (int b = 0; b < 39; b++) begin
                logic [38:0] v;
                v = flip1(words[w], cw, b);
                if (w < 2)
                    drive(2'b10, 1'b1, v[31:0], v[38:32], mk(v[31:0], 1, v[38:32], 7'h7F, 0, 1, "R3 single flip flag"));
                if (b >= 32)
                    drive(2'b11, 1'b1, v[31:0], v[38:32],
                          mk(words[w], 1, ~(7'd1 << (b - 32)), 7'h7F, 0, 1, "R6 R5 check-bit flip"));
                else
                    drive(2'b11, 1'b1, v[31:0], v[38:32], mk(words[w], 1, 7'h0, 7'h0, 0, 1, "R5 R3 data flip"));
                // R4: double flips, all three kinds over the sweep
                begin
                    int j;
                    logic [38:0] v2;
                    j = (b + 1 + (b * 5) % 37) % 39;
                    v2 = v ^ (39'd1 << j);
                    drive(2'b11, 1'b1, v2[31:0], v2[38:32], mk(32'h0, 0, 7'h0, 7'h0, 0, 0, "R4 double flip"));
                end
            end
        end

        // R7: data-bit syndromes distinct with odd zero count >= 3
        encode(words[3], cw);
        for (int j = 0; j < 32; j++) begin
            logic [38:0] v;
            int nz;
            v = flip1(words[3], cw, j);
            @(posedge clk); #2;
            mode_sel = 2'b11; lat_en = 1'b1; data_in = v[31:0]; chk_in = v[38:32];
            @(negedge clk); #1;
            syns[j] = chk_out;
            nz = $countones(~chk_out);
            checks++;
            if (nz < 3 || nz % 2 == 0) begin
                errors++;
                $display("FAIL R7 bit %0d: syndrome zeros=%0d expected odd >=3", j, nz);
            end
            for (int k = 0; k < j; k++) begin
                checks++;
                if (syns[k] == syns[j]) begin
                    errors++;
                    $display("FAIL R7 bits %0d/%0d: syndrome %h equals %h expected distinct", k, j, syns[j], syns[k]);
                end
            end
        end

        // R8: capture, hold against changing live inputs, then follow again
        encode(words[2], cw);
        begin
            logic [38:0] v;
            v = flip1(words[2], cw, 5);
            drive(2'b11, 1'b1, v[31:0], v[38:32], mk(words[2], 1, 7'h0, 7'h0, 0, 1, "R8 capture"));
            drive(2'b11, 1'b0, 32'h1357_9BDF, 7'h2A, mk(words[2], 1, 7'h0, 7'h0, 0, 1, "R8 hold 1"));
            drive(2'b11, 1'b0, 32'hFFFF_0000, 7'h11, mk(words[2], 1, 7'h0, 7'h0, 0, 1, "R8 hold 2"));
            drive(2'b10, 1'b0, 32'h0, 7'h0, mk(v[31:0], 1, v[38:32], 7'h7F, 0, 1, "R8 hold flag mode"));
            drive(2'b11, 1'b1, words[2], cw, mk(words[2], 1, 7'h7F, 7'h7F, 1, 1, "R8 follow live"));
        end

        @(negedge clk); #1;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule